// File: doc/BRIEF.md
# Adaptive Multi-Cycle Row Write Sequencer

This controller runs writes into one row of a bit-interleaved memory whose row holds several words side by side, with bit `i` of word `w` placed at column `WAYS*i + w`. After a write request is taken, it keeps the write word-line on for as many whole clock cycles as the slowest cell of the target word needs. The clock is never slowed; cycles are added instead. The row is read back in every one of those cycles, and the write stops as soon as the target word that was read back equals the data being written.

The first cycle uses the low word-line level. In that cycle only the target columns are driven, and the other words of the row, which are half-selected, are simply read. Their read-out is kept in a holding register. From the second cycle on, the word-line level is switched to boosted, and every half-selected column is driven with its own captured value, so the stronger word-line cannot disturb those cells. A write that has not completed after `MAX_CYC` cycles is abandoned and flagged as failed. Every write reports how many cycles it used.

Top module: `adaptive_write_ctrl`

## Requirements
- R1: A request is taken only on a clock edge where `req_ready` is high. `req_ready` is high exactly when the block is idle, is low from the edge that takes a request until the edge that raises `wr_done` or `wr_fail`, and is high again while that flag is high. A request presented while the block is busy has no effect on the row.
- R2: From the cycle after acceptance until the write ends, `wwl_en` stays high without a gap, and `rd_strobe` is high in every one of those cycles. Both are low when the block is idle.
- R3: `vsel_high` is 0 in the first cycle of a write and 1 in every later cycle of the same write.
- R4: The write ends at the first edge where the read-back target word (`rd_data` bits `WAYS*i+sel`) equals the write data. `wr_done` pulses for one cycle and `cycles_used` gives the number of word-line cycles. That number is 1 when the low-level cycle already succeeds, and 1+k when the slowest changing cell needs k boosted cycles.
- R5: In the first cycle, only the `WORD_W` target columns have `bl_drv_en` set. Every half-selected column is undriven.
- R6: From the second cycle on, all `ROW_W` columns are driven. Each half-selected column carries the value read from it in the first cycle, so half-selected words are left unchanged by the write.
- R7: Every target column `WAYS*i+sel` is driven with bit `i` of the write data in every cycle of the write. After `wr_done`, the target word holds the data.
- R8: If the word still does not match at the end of cycle `MAX_CYC`, the write ends with a one-cycle `wr_fail` pulse instead of `wr_done`, and `cycles_used` equals `MAX_CYC`.
- R9: `wr_done` and `wr_fail` are never high together.
- R10: After reset, `req_ready` is 1, and `wwl_en`, `vsel_high`, `wr_done`, `wr_fail` and every `bl_drv_en` bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Write request |
| req_ready | output | 1 | Block is idle and takes a request |
| req_sel | input | SEL_W | Target word within the row |
| req_data | input | WORD_W | Data to write |
| wwl_en | output | 1 | Write word-line enable |
| rd_strobe | output | 1 | Read word-line pulse, once per write cycle |
| vsel_high | output | 1 | 0 selects the low word-line level, 1 the boosted level |
| bl_drv_en | output | ROW_W | Per-column bit-line drive enable |
| bl_drv_val | output | ROW_W | Per-column bit-line drive value |
| rd_data | input | ROW_W | Row read-out of the current cycle |
| wr_done | output | 1 | Write completed (one cycle) |
| wr_fail | output | 1 | Write gave up at the cycle limit (one cycle) |
| cycles_used | output | CNT_W | Cycles used by the last write |

## Verification
The bench builds the block with 8-bit words, four words per row (32 columns) and a limit of 4 cycles. At that size, every target word select can be swept together with many data patterns and with per-cell needs of 0 to 3 boosted cycles. This covers every possible write length, as well as the cases where the first cycle already matches and where a cell never writes and must hit the limit. The behavioural row model inverts any undriven half-selected cell under the boosted level, so a missing or wrong regeneration shows up as corruption of a neighbour word. The expected length of each write is computed as one plus the largest need among the cells that must change.

// File: rtl/adaptive_write_ctrl.sv
module adaptive_write_ctrl #(
  parameter int WORD_W  = 32,
  parameter int WAYS    = 4,
  parameter int MAX_CYC = 4,
  localparam int ROW_W  = WORD_W * WAYS,
  localparam int SEL_W  = $clog2(WAYS),
  localparam int CNT_W  = $clog2(MAX_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [WORD_W-1:0] req_data,
  output logic              wwl_en,
  output logic              rd_strobe,
  output logic              vsel_high,
  output logic [ROW_W-1:0]  bl_drv_en,
  output logic [ROW_W-1:0]  bl_drv_val,
  input  logic [ROW_W-1:0]  rd_data,
  output logic              wr_done,
  output logic              wr_fail,
  output logic [CNT_W-1:0]  cycles_used
);

  logic              busy, first;
  logic [CNT_W-1:0]  cyc;
  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] data_q, rd_word;
  logic [ROW_W-1:0]  hold_q, tgt_mask, wr_row;
  logic              match, at_limit;

  always_comb begin
    rd_word  = '0;
    tgt_mask = '0;
    wr_row   = '0;
    for (int i = 0; i < WORD_W; i++) begin
      for (int w = 0; w < WAYS; w++) begin
        tgt_mask[WAYS*i + w] = (sel_q == SEL_W'(w));
        wr_row[WAYS*i + w]   = data_q[i];
        if (sel_q == SEL_W'(w)) rd_word[i] = rd_data[WAYS*i + w];
      end
    end
  end

  assign match      = (rd_word == data_q);
  assign at_limit   = (cyc == CNT_W'(MAX_CYC));
  assign req_ready  = !busy;
  assign wwl_en     = busy;
  assign rd_strobe  = busy;
  assign vsel_high  = busy && !first;
  assign bl_drv_en  = !busy ? '0 : (first ? tgt_mask : '1);
  assign bl_drv_val = (tgt_mask & wr_row) | (~tgt_mask & hold_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      first       <= 1'b0;
      cyc         <= '0;
      sel_q       <= '0;
      data_q      <= '0;
      hold_q      <= '0;
      wr_done     <= 1'b0;
      wr_fail     <= 1'b0;
      cycles_used <= '0;
    end else begin
      wr_done <= 1'b0;
      wr_fail <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy   <= 1'b1;
          first  <= 1'b1;
          cyc    <= CNT_W'(1);
          sel_q  <= req_sel;
          data_q <= req_data;
        end
      end else begin
        first <= 1'b0;
        if (first) hold_q <= rd_data;
        if (match) begin
          busy        <= 1'b0;
          wr_done     <= 1'b1;
          cycles_used <= cyc;
        end else if (at_limit) begin
          busy        <= 1'b0;
          wr_fail     <= 1'b1;
          cycles_used <= cyc;
        end else begin
          cyc <= cyc + CNT_W'(1);
        end
      end
    end
  end

  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_done && wr_fail));

  // R1
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wwl_en |-> !req_ready);

  // R2
  wl_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wwl_en) |-> (wr_done || wr_fail));

  // R3
  first_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wwl_en) |-> !vsel_high);

  // R3
  later_boost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wwl_en && $past(wwl_en) && !$past(wr_done || wr_fail)) |-> vsel_high);

  // R5
  first_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wwl_en) |-> ($countones(bl_drv_en) == WORD_W));

  // R6
  boost_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsel_high |-> ($countones(bl_drv_en) == ROW_W));

  // R8
  fail_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fail |-> (cycles_used == CNT_W'(MAX_CYC)));

endmodule

// File: tb/sim_adaptive_write_ctrl.sv
`timescale 1ns/1ps
module sim_adaptive_write_ctrl;
  localparam int W = 8;
  localparam int K = 4;
  localparam int M = 4;
  localparam int R = W * K;
  localparam int SW = 2;
  localparam int CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [SW-1:0] req_sel = '0;
  logic [W-1:0]  req_data = '0;
  logic wwl_en, rd_strobe, vsel_high, wr_done, wr_fail;
  logic [R-1:0] bl_drv_en, bl_drv_val, rd_data;
  logic [CW-1:0] cycles_used;

  always #2.5 clk = ~clk;

  adaptive_write_ctrl #(.WORD_W(W), .WAYS(K), .MAX_CYC(M)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_data(req_data), .wwl_en(wwl_en), .rd_strobe(rd_strobe),
    .vsel_high(vsel_high), .bl_drv_en(bl_drv_en), .bl_drv_val(bl_drv_val),
    .rd_data(rd_data), .wr_done(wr_done), .wr_fail(wr_fail), .cycles_used(cycles_used));

  // behavioural row: need[c] = boosted cycles cell c needs; undriven cells flip under boost
  int need [R];
  logic [R-1:0] cells = '0;
  int hc = 0;
  int hc_after;
  always_comb begin
    hc_after = hc + (vsel_high ? 1 : 0);
    for (int c = 0; c < R; c++) begin
      if (wwl_en && bl_drv_en[c])
        rd_data[c] = (need[c] <= hc_after) ? bl_drv_val[c] : cells[c];
      else if (wwl_en && vsel_high)
        rd_data[c] = ~cells[c];
      else
        rd_data[c] = cells[c];
    end
  end
  always @(posedge clk) begin
    if (wwl_en) begin cells <= rd_data; hc <= hc_after; end
    else hc <= 0;
  end

  int checks = 0, errors = 0;
  int tot_cyc = 0, n_writes = 0, max_cyc = 0;
  int unsigned seed = 32'h1234_5678;

  function automatic int unsigned nxt(inout int unsigned s);
    s ^= s << 13; s ^= s >> 17; s ^= s << 5;
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic do_write(input int sel, input logic [W-1:0] data, input bit poke);
    logic [R-1:0] old;
    int mx, exp_cyc, n;
    bit exp_fail;
    old = cells;
    mx = 0;
    for (int i = 0; i < W; i++)
      if (cells[K*i+sel] != data[i] && need[K*i+sel] > mx) mx = need[K*i+sel];
    exp_cyc = 1 + mx;
    exp_fail = exp_cyc > M;
    if (exp_fail) exp_cyc = M;

    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_sel = SW'(sel); req_data = data;
    @(negedge clk);
    req_valid = poke; req_data = ~data; req_sel = SW'(sel ^ 1);
    n = 1;
    while (!(wr_done || wr_fail) && n <= M + 2) begin
      chk(wwl_en == 1'b1, "R2 word-line held", int'(wwl_en), 1);
      chk(rd_strobe == 1'b1, "R2 read strobe each cycle", int'(rd_strobe), 1);
      chk(req_ready == 1'b0, "R1 ready low while busy", int'(req_ready), 0);
      chk(vsel_high == (n > 1), "R3 voltage select", int'(vsel_high), int'(n > 1));
      if (n == 1)
        chk($countones(bl_drv_en) == W, "R5 first cycle drives only target", $countones(bl_drv_en), W);
      else
        chk($countones(bl_drv_en) == R, "R6 later cycles drive all columns", $countones(bl_drv_en), R);
      for (int i = 0; i < W; i++)
        if (!bl_drv_en[K*i+sel] || bl_drv_val[K*i+sel] != data[i])
          chk(1'b0, "R7 target column drive", int'(bl_drv_val[K*i+sel]), int'(data[i]));
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    chk(!(wr_done && wr_fail), "R9 done and fail exclusive", int'(wr_done && wr_fail), 0);
    chk(wr_fail == exp_fail, "R8 fail flag", int'(wr_fail), int'(exp_fail));
    chk(wr_done == !exp_fail, "R4 done flag", int'(wr_done), int'(!exp_fail));
    chk(int'(cycles_used) == exp_cyc, exp_fail ? "R8 cycles at limit" : "R4 cycles used",
        int'(cycles_used), exp_cyc);
    chk(n - 1 == exp_cyc, "R2 word-line length", n - 1, exp_cyc);
    chk(req_ready == 1'b1 && wwl_en == 1'b0, "R1 ready back with flag", int'(req_ready), 1);
    if (!exp_fail)
      for (int i = 0; i < W; i++)
        if (cells[K*i+sel] != data[i])
          chk(1'b0, "R7 target word written", int'(cells[K*i+sel]), int'(data[i]));
    for (int c = 0; c < R; c++)
      if ((c % K) != sel && cells[c] != old[c])
        chk(1'b0, poke ? "R1 busy request ignored" : "R6 half-selected kept",
            int'(cells[c]), int'(old[c]));
    checks++;
    @(negedge clk);
    chk(wr_done == 1'b0 && wr_fail == 1'b0, "R9 flags one cycle", int'(wr_done | wr_fail), 0);
    tot_cyc += int'(cycles_used);
    n_writes++;
    if (int'(cycles_used) > max_cyc) max_cyc = int'(cycles_used);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
    $finish;
  end

  initial begin
    logic [W-1:0] d;
    for (int c = 0; c < R; c++) need[c] = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10 reset ready", int'(req_ready), 1);
    chk(wwl_en == 1'b0 && vsel_high == 1'b0, "R10 reset word-line", int'(wwl_en), 0);
    chk(wr_done == 1'b0 && wr_fail == 1'b0, "R10 reset flags", int'(wr_done | wr_fail), 0);
    chk(bl_drv_en == '0, "R10 reset drives", int'(bl_drv_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 ready after release
    chk(req_ready == 1'b1, "R10 ready after release", int'(req_ready), 1);

    // half-selected neighbours start non-trivial
    for (int sel = 0; sel < K; sel++) do_write(sel, W'(8'hA5 ^ (sel * 8'h3C)), 1'b0);

    for (int sel = 0; sel < K; sel++) begin
      for (int t = 0; t < 40; t++) begin
        for (int c = 0; c < R; c++) need[c] = int'(nxt(seed) % 4);
        d = W'(nxt(seed));
        // R4 all-low-level case
        if (t == 0) for (int c = 0; c < R; c++) need[c] = 0;
        // R4 every changing bit needs the maximum
        if (t == 1) for (int c = 0; c < R; c++) need[c] = M - 1;
        do_write(sel, d, t % 3 == 0);
        // R4 rewrite of identical data: match in first cycle
        if (t % 8 == 2) do_write(sel, d, 1'b0);
        // R8 a cell that never writes
        if (t % 10 == 5) begin
          for (int i = 0; i < W; i++) need[K*i+sel] = 0;
          need[K*3+sel] = 99;
          do_write(sel, ~d, 1'b0);
        end
      end
    end

    $display("writes=%0d average_x100=%0d max=%0d", n_writes, (tot_cyc * 100) / n_writes, max_cyc);
    chk(max_cyc <= M, "R8 maximum write length", max_cyc, M);
    chk(max_cyc == M, "R4 longest write reached", max_cyc, M);
    report();
    $finish;
  end
endmodule